// File: doc/BRIEF.md
# Adaptive Stepper Pulse Driver

This block drives the H-bridge of a two-coil watch stepper motor from a 32768 Hz clock. Once per output period it fires a drive pulse, with the polarity reversed from one pulse to the next. Each pulse is chopped in 16-cycle slices to a duty cycle set by the current drive stage. A pulse can optionally be followed by a weak stretch pulse.

After the drive has ended, the block watches the back-EMF comparator flags for a step signature: a positive flag, then a negative flag inside a programmable time limit. A missed step raises the drive stage for the next pulse. A long run of good steps lowers it again. The analog sensing, the comparators and the calibrated time base sit outside the block.

A clock divider and the comparator front end feed the block. Its outputs control the four bridge switches directly.

Top module: `adaptive_step_driver`

## Requirements
- R1: While reset is asserted all four switch outputs and step_fail are 0. One cycle after run_en is low, all four switches are open.
- R2: After run_en rises, the first pulse drives the bridge after exactly P cycles, and later pulses start every P cycles. P = SEC_CYC × M, where M is 1, 5, 10 or 20 for period_sel 00, 01, 10 or 11.
- R3: Pulses alternate polarity. The first pulse after reset closes sw_hs_a with sw_ls_b, and the next closes sw_hs_b with sw_ls_a. The two high-side switches are never closed together.
- R4: The main pulse lasts (width_sel+1)×PW_UNIT cycles. In every 16-cycle slice the switches are closed for the first D cycles. Below the top stage, D = 6 + low_duty_sel + stage, with stage 0 the lowest.
- R5: With stretch_en = 1 the main pulse is followed by 2×(width_sel+1)×PW_UNIT cycles at D = 4.
- R6: A step counts as made when det_pos is seen during the sense window and det_neg follows 1 to L cycles later, with L = (4+limit_sel)×LIM_UNIT. The sense window runs from the end of the drive (main plus stretch) to DET_END cycles after pulse start.
- R7: When the window closes without a step, step_fail is high for exactly one cycle, and the next pulse uses the stage one higher.
- R8: After RELAX_CNT consecutive pulses without a miss, the stage drops by one, never below stage 0.
- R9: The top stage (index 2 + stage_cnt_sel) does no detection, never reports a miss, and counts as a good step. Its duty is 12/16 when top_full = 0 and 16/16 when top_full = 1.
- R10: Detection flags seen while the drive or stretch is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Enables pulsing; low opens the bridge and restarts the period |
| low_duty_sel | input | 2 | Lowest-stage duty: 6+code sixteenths |
| stage_cnt_sel | input | 2 | Number of stages minus 3 |
| top_full | input | 1 | Top-stage duty 16/16 (1) or 12/16 (0) |
| stretch_en | input | 1 | Append stretch pulse |
| period_sel | input | 2 | Output period multiplier select |
| width_sel | input | 3 | Main pulse width select |
| limit_sel | input | 3 | Positive-to-negative detection limit select |
| det_pos | input | 1 | Sampled positive detection flag |
| det_neg | input | 1 | Sampled negative detection flag |
| sw_hs_a | output | 1 | High-side switch, coil end A |
| sw_ls_a | output | 1 | Low-side switch, coil end A |
| sw_hs_b | output | 1 | High-side switch, coil end B |
| sw_ls_b | output | 1 | Low-side switch, coil end B |
| step_fail | output | 1 | One-cycle pulse on a missed step |

## Verification
The bench builds the block with SEC_CYC = 1280 and RELAX_CNT = 4, and leaves the pulse, limit and window units at their defaults. A full period then fits a complete 1024-cycle sense window while lasting only a few dozen microseconds of simulation. Escalation to the top stage, a fall back after four good pulses, the exact limit boundary, stretching and the 5× period all fit in a short run.

// File: rtl/adaptive_step_pkg.sv
package adaptive_step_pkg;
    localparam int CHOP_LEN     = 16;  // slice length of the chopper
    localparam int BASE_DUTY    = 6;   // 37.5 % in sixteenths
    localparam int TOP_DUTY_LOW = 12;  // 75 %
    localparam int STRETCH_DUTY = 4;   // 25 %

    function automatic int period_mult(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 5;
            2'b10:   return 10;
            default: return 20;
        endcase
    endfunction
endpackage

// File: rtl/adaptive_step_chop.sv
module adaptive_step_chop
    import adaptive_step_pkg::*;
(
    input  logic [2:0] stage,
    input  logic [2:0] top_idx,
    input  logic [1:0] low_sel,
    input  logic       top_full,
    input  logic       main_on,
    input  logic       stretch_on,
    input  logic [3:0] slice_pos,
    output logic       drive_on
);
    logic [4:0] duty;
    logic [4:0] level;

    always_comb begin
        if (stage == top_idx)
            duty = top_full ? 5'(CHOP_LEN) : 5'(TOP_DUTY_LOW);
        else
            duty = 5'(BASE_DUTY) + {3'b000, low_sel} + {2'b00, stage};
        if (main_on)
            level = duty;
        else if (stretch_on)
            level = 5'(STRETCH_DUTY);
        else
            level = 5'd0;
    end

    assign drive_on = {1'b0, slice_pos} < level;
endmodule

// File: rtl/adaptive_step_judge.sv
module adaptive_step_judge #(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic          pos,
    input  logic          neg,
    input  logic [LW-1:0] limit,
    output logic          hit
);
    typedef struct packed {
        logic          armed;
        logic [LW-1:0] gap;
        logic          hit;
    } judge_t;

    judge_t j_d, j_q;

    always_comb begin
        j_d = j_q;
        if (clear) begin
            j_d = '0;
        end else if (en && !j_q.hit) begin
            if (j_q.armed) begin
                if (neg)
                    j_d.hit = 1'b1;
                else if (j_q.gap == limit - 1'b1)
                    j_d.armed = 1'b0;
                else
                    j_d.gap = j_q.gap + 1'b1;
            end else if (pos) begin
                j_d.armed = 1'b1;
                j_d.gap   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) j_q <= '0;
        else        j_q <= j_d;
    end

    assign hit = j_d.hit;
endmodule

// File: rtl/adaptive_step_stage.sv
module adaptive_step_stage #(
    parameter int RELAX_CNT = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    input  logic       ok,
    input  logic [2:0] top_idx,
    output logic [2:0] stage
);
    localparam int CW = $clog2(RELAX_CNT + 1);

    typedef struct packed {
        logic [2:0]    stage;
        logic [CW-1:0] run;
    } stage_t;

    stage_t g_d, g_q;
    logic [2:0] eff;

    assign eff = (g_q.stage > top_idx) ? top_idx : g_q.stage;

    always_comb begin
        g_d = g_q;
        if (done) begin
            g_d.stage = eff;
            if (!ok) begin
                g_d.run = '0;
                if (eff != top_idx) g_d.stage = eff + 3'd1;
            end else if (g_q.run == CW'(RELAX_CNT - 1)) begin
                g_d.run = '0;
                if (eff != 3'd0) g_d.stage = eff - 3'd1;
            end else begin
                g_d.run = g_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign stage = eff;
endmodule

// File: rtl/adaptive_step_driver.sv
module adaptive_step_driver
    import adaptive_step_pkg::*;
#(
    parameter int SEC_CYC   = 32768,
    parameter int PW_UNIT   = 32,
    parameter int LIM_UNIT  = 32,
    parameter int DET_END   = 1024,
    parameter int RELAX_CNT = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic [1:0] low_duty_sel,
    input  logic [1:0] stage_cnt_sel,
    input  logic       top_full,
    input  logic       stretch_en,
    input  logic [1:0] period_sel,
    input  logic [2:0] width_sel,
    input  logic [2:0] limit_sel,
    input  logic       det_pos,
    input  logic       det_neg,
    output logic       sw_hs_a,
    output logic       sw_ls_a,
    output logic       sw_hs_b,
    output logic       sw_ls_b,
    output logic       step_fail
);
    localparam int PER_W = $clog2(SEC_CYC * 20);
    localparam int TW    = $clog2(DET_END);
    localparam int LW    = $clog2(11 * LIM_UNIT + 1);

    typedef struct packed {
        logic             active;
        logic [TW-1:0]    t;
        logic [PER_W-1:0] per;
        logic             pol;
        logic             fail;
    } drv_t;

    drv_t s_d, s_q;

    logic [PER_W-1:0] per_last;
    logic [TW-1:0]    tp, drive_end;
    logic [LW-1:0]    limit;
    logic [2:0]       top_idx, stage_eff;
    logic             main_on, stretch_on, in_sense, at_top;
    logic             start, last, done, hit, ok, drive_on;

    assign per_last  = PER_W'(SEC_CYC * period_mult(period_sel) - 1);
    assign tp        = TW'((int'(width_sel) + 1) * PW_UNIT);
    assign drive_end = stretch_en ? TW'(3 * (int'(width_sel) + 1) * PW_UNIT) : tp;
    assign limit     = LW'((int'(limit_sel) + 4) * LIM_UNIT);
    assign top_idx   = 3'd2 + {1'b0, stage_cnt_sel};
    assign at_top    = (stage_eff == top_idx);

    assign main_on    = s_q.active && (s_q.t < tp);
    assign stretch_on = s_q.active && stretch_en && !main_on && (s_q.t < drive_end);
    assign in_sense   = s_q.active && (s_q.t >= drive_end);

    assign start = run_en && (s_q.per >= per_last);
    assign last  = s_q.active && (s_q.t == TW'(DET_END - 1));
    assign done  = run_en && last;
    assign ok    = at_top || hit;

    adaptive_step_judge #(.LW(LW)) u_judge (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .en    (in_sense && !at_top),
        .pos   (det_pos),
        .neg   (det_neg),
        .limit (limit),
        .hit   (hit)
    );

    adaptive_step_stage #(.RELAX_CNT(RELAX_CNT)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done),
        .ok      (ok),
        .top_idx (top_idx),
        .stage   (stage_eff)
    );

    adaptive_step_chop u_chop (
        .stage      (stage_eff),
        .top_idx    (top_idx),
        .low_sel    (low_duty_sel),
        .top_full   (top_full),
        .main_on    (main_on),
        .stretch_on (stretch_on),
        .slice_pos  (s_q.t[3:0]),
        .drive_on   (drive_on)
    );

    always_comb begin
        s_d      = s_q;
        s_d.fail = 1'b0;
        if (!run_en) begin
            s_d.active = 1'b0;
            s_d.per    = '0;
        end else begin
            if (s_q.active) begin
                if (last) begin
                    s_d.active = 1'b0;
                    s_d.fail   = !ok;
                end else begin
                    s_d.t = s_q.t + 1'b1;
                end
            end
            if (start) begin
                s_d.per    = '0;
                s_d.active = 1'b1;
                s_d.t      = '0;
                s_d.pol    = !s_q.pol;
            end else begin
                s_d.per = s_q.per + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{active: 1'b0, t: '0, per: '0, pol: 1'b1, fail: 1'b0};
        else
            s_q <= s_d;
    end

    assign sw_hs_a   = drive_on && !s_q.pol;
    assign sw_ls_b   = drive_on && !s_q.pol;
    assign sw_hs_b   = drive_on && s_q.pol;
    assign sw_ls_a   = drive_on && s_q.pol;
    assign step_fail = s_q.fail;
endmodule

// File: rtl/adaptive_step_driver_chk.sv
module adaptive_step_driver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       run_en,
    input logic       sw_hs_a,
    input logic       sw_ls_a,
    input logic       sw_hs_b,
    input logic       sw_ls_b,
    input logic       step_fail,
    input logic [2:0] stage
);
    a_r1_off_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !(sw_hs_a || sw_ls_a || sw_hs_b || sw_ls_b));

    a_r3_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_hs_a && sw_hs_b) && !(sw_ls_a && sw_ls_b));

    a_r3_pair_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_hs_a == sw_ls_b) && (sw_hs_b == sw_ls_a));

    a_r7_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
        step_fail |=> !step_fail);

    a_r7_fail_raises: assert property (@(posedge clk) disable iff (!rst_n)
        step_fail |-> (stage == $past(stage) + 3'd1));
endmodule

bind adaptive_step_driver adaptive_step_driver_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .sw_hs_a   (sw_hs_a),
    .sw_ls_a   (sw_ls_a),
    .sw_hs_b   (sw_hs_b),
    .sw_ls_b   (sw_ls_b),
    .step_fail (step_fail),
    .stage     (stage_eff)
);

// File: tb/adaptive_step_driver_tb.sv
module adaptive_step_driver_tb;
    localparam int SEC  = 1280;
    localparam int RLX  = 4;
    localparam int DEND = 1024;
    localparam int POS_AT = 600;

    logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0;
    logic [1:0] low_duty_sel = 2'b00, stage_cnt_sel = 2'b00, period_sel = 2'b00;
    logic top_full = 1'b0, stretch_en = 1'b0;
    logic [2:0] width_sel = 3'd0, limit_sel = 3'd0;
    logic det_pos = 1'b0, det_neg = 1'b0;
    logic sw_hs_a, sw_ls_a, sw_hs_b, sw_ls_b, step_fail;
    logic [3:0] pins;

    int n_chk = 0, n_fail = 0, fails = 0;
    int resp_mode = 0, resp_gap = 0;
    int lat, on, pair;

    // reference model state
    int m_active, m_t, m_per, m_pol, m_fail, m_armed, m_gap, m_hit, m_stage, m_cnt;
    int r_len, r_tp, r_dend, r_top, r_eff, r_lim;

    always #4 clk = ~clk;

    assign pins = {sw_hs_a, sw_ls_a, sw_hs_b, sw_ls_b};

    adaptive_step_driver #(.SEC_CYC(SEC), .RELAX_CNT(RLX)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .low_duty_sel(low_duty_sel), .stage_cnt_sel(stage_cnt_sel),
        .top_full(top_full), .stretch_en(stretch_en), .period_sel(period_sel),
        .width_sel(width_sel), .limit_sel(limit_sel),
        .det_pos(det_pos), .det_neg(det_neg),
        .sw_hs_a(sw_hs_a), .sw_ls_a(sw_ls_a), .sw_hs_b(sw_hs_b), .sw_ls_b(sw_ls_b),
        .step_fail(step_fail)
    );

    function automatic int mult(input int s);
        if (s == 0) return 1;
        if (s == 1) return 5;
        if (s == 2) return 10;
        return 20;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 0; m_t = 0; m_per = 0; m_pol = 1; m_fail = 0;
            m_armed = 0; m_gap = 0; m_hit = 0; m_stage = 0; m_cnt = 0;
        end else begin
            r_len  = SEC * mult(int'(period_sel));
            r_tp   = (int'(width_sel) + 1) * 32;
            r_dend = stretch_en ? 3 * r_tp : r_tp;
            r_top  = 2 + int'(stage_cnt_sel);
            r_eff  = (m_stage > r_top) ? r_top : m_stage;
            r_lim  = (4 + int'(limit_sel)) * 32;
            m_fail = 0;
            if (!run_en) begin
                m_active = 0; m_per = 0;
            end else begin
                if (m_active != 0) begin
                    if (m_t >= r_dend && m_hit == 0 && r_eff != r_top) begin
                        if (m_armed != 0) begin
                            if (det_neg) m_hit = 1;
                            else if (m_gap == r_lim - 1) m_armed = 0;
                            else m_gap++;
                        end else if (det_pos) begin
                            m_armed = 1; m_gap = 0;
                        end
                    end
                    if (m_t == DEND - 1) begin
                        m_active = 0;
                        if (r_eff == r_top || m_hit != 0) begin
                            m_cnt++;
                            m_stage = r_eff;
                            if (m_cnt == RLX) begin
                                m_cnt = 0;
                                if (m_stage > 0) m_stage--;
                            end
                        end else begin
                            m_fail = 1; m_cnt = 0;
                            m_stage = (r_eff < r_top) ? r_eff + 1 : r_top;
                        end
                    end else m_t++;
                end
                if (m_per >= r_len - 1) begin
                    m_per = 0; m_active = 1; m_t = 0; m_pol = 1 - m_pol;
                    m_armed = 0; m_gap = 0; m_hit = 0;
                end else m_per++;
            end
        end
    end

    function automatic logic [4:0] expect_out();
        int tp, top, eff, d;
        logic o;
        tp  = (int'(width_sel) + 1) * 32;
        top = 2 + int'(stage_cnt_sel);
        eff = (m_stage > top) ? top : m_stage;
        d   = (eff == top) ? (top_full ? 16 : 12) : 6 + int'(low_duty_sel) + eff;
        o = (m_active != 0) &&
            ((m_t < tp && (m_t % 16) < d) ||
             (stretch_en && m_t >= tp && m_t < 3 * tp && (m_t % 16) < 4));
        return {o && m_pol == 0, o && m_pol == 1, o && m_pol == 1, o && m_pol == 0,
                m_fail != 0};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // stimulus for detection flags and per-cycle comparison
    initial begin
        forever begin
            @(negedge clk);
            det_pos = (m_active != 0) &&
                      ((resp_mode == 1 && m_t == POS_AT) || (resp_mode == 2 && m_t == 5));
            det_neg = (m_active != 0) &&
                      ((resp_mode == 1 && m_t == POS_AT + resp_gap) ||
                       (resp_mode == 2 && m_t == 10));
            if (rst_n) begin
                if (step_fail) fails++;
                chk("R3/R4/R7 cycle compare {hs_a,ls_a,hs_b,ls_b,fail}",
                    int'({pins, step_fail}), int'(expect_out()));
            end
        end
    end

    task automatic measure(output int l, output int o, output int p);
        l = 0;
        do begin
            @(negedge clk);
            l++;
        end while (pins == 4'b0000);
        p = sw_hs_a ? 1 : 2;
        o = 1;
        repeat (DEND - 1) begin
            @(negedge clk);
            if (pins != 4'b0000) o++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 outputs in reset", int'({pins, step_fail}), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 idle with run low", int'({pins, step_fail}), 0);

        resp_mode = 1; resp_gap = 50; run_en = 1'b1;
        measure(lat, on, pair);
        chk("R2 first pulse latency", lat, SEC);
        chk("R4 stage0 duty 6/16", on, 12);
        chk("R3 first pulse pair A", pair, 1);

        resp_gap = 128;
        measure(lat, on, pair);
        chk("R3 second pulse pair B", pair, 2);
        chk("R6 neg at limit is a step", fails, 0);

        resp_gap = 129;
        measure(lat, on, pair);
        chk("R6 neg past limit is a miss", fails, 1);

        resp_mode = 0;
        measure(lat, on, pair);
        chk("R7 raised stage duty 7/16", on, 14);
        chk("R7 second miss reported", fails, 2);

        measure(lat, on, pair);
        chk("R9 top duty 12/16", on, 24);
        chk("R9 no miss at top", fails, 2);
        measure(lat, on, pair);
        measure(lat, on, pair);
        measure(lat, on, pair);
        chk("R9 still top before relax", on, 24);

        resp_mode = 1; resp_gap = 50;
        measure(lat, on, pair);
        chk("R8 relax back one stage", on, 14);

        resp_mode = 2;
        measure(lat, on, pair);
        chk("R10 flags during drive ignored", fails, 3);

        top_full = 1'b1; resp_mode = 0;
        measure(lat, on, pair);
        chk("R9 top duty 16/16", on, 32);

        while (pins == 4'b0000) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        chk("R1 run low opens bridge", int'(pins), 0);

        stretch_en = 1'b1; period_sel = 2'b01;
        repeat (10) @(negedge clk);
        run_en = 1'b1;
        measure(lat, on, pair);
        chk("R2 period x5 latency", lat, 5 * SEC);
        chk("R5 stretch adds 2tp at 4/16", on, 48);
        finish_run();
    end
endmodule